// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Control

This block is the hazard controller of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, and write-back. It is purely combinational. Each cycle it compares the source register numbers of the instruction in execute with the destination numbers held in the execute/memory and memory/write-back pipeline registers. From these matches it drives one 2-bit select per source operand for the bypass multiplexers at the ALU inputs. As a result, an ALU result can feed the very next instruction with no lost cycle.

The register file is assumed to return the value being written when a register is read and written in the same cycle. Because of this, nothing needs to be bypassed from write-back into decode. Only two bypass sources exist.

A load has one case that bypassing cannot cover: the instruction directly after it reads the loaded register. In that case the block detects the load in execute and a matching source register in decode. For one cycle it holds the program counter and the fetch/decode register, so the same instruction is fetched again and decode keeps its content. In that same cycle it tells the decode/execute register to insert a bubble, with all control fields forced to zero. On the next cycle the load has moved on and the stall drops. The dependent instruction then takes the loaded value from the memory/write-back register.

Top module: `hazard_unit`

## Requirements
- R1: When an execute-stage source equals the execute/memory destination, that register's write flag is set and the number is not zero, the operand's select is 2'b10.
- R2: When an execute-stage source matches the memory/write-back destination under the same rules and R1 does not apply, the select is 2'b01.
- R3: When both later stages match the same source, the execute/memory value wins and the select is 2'b10.
- R4: When neither later stage matches, the select is 2'b00, which picks the register file value.
- R5: A destination of register zero never causes a bypass or a stall.
- R6: A stage whose register-write flag is low never causes a bypass.
- R7: When execute holds a load and its destination, written and non-zero, equals either decode source, the PC write enable and the fetch/decode write enable are 0 and bubble insert is 1.
- R8: An instruction in execute that is not a load never stalls, even when its destination matches a decode source. A load whose destination is register zero also never stalls.
- R9: A load-use pair costs exactly one stall cycle. Once the bubble sits in execute and the load sits in memory, the stall is released. One cycle later the consumer in execute selects 2'b01.
- R10: Each operand's select depends only on its own source number. Operand 0 uses source bits [REG_W-1:0] and select bits [1:0]. Operand 1 uses source bits [2*REG_W-1:REG_W] and select bits [3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_i | input | NUM_SRC*REG_W | Source register numbers of the instruction in decode |
| exe_src_i | input | NUM_SRC*REG_W | Source register numbers of the instruction in execute |
| exe_rd_i | input | REG_W | Destination register of the instruction in execute |
| exe_load_i | input | 1 | Instruction in execute reads data memory |
| exe_regwr_i | input | 1 | Instruction in execute writes a register |
| mem_rd_i | input | REG_W | Destination held in the execute/memory register |
| mem_regwr_i | input | 1 | Register-write flag in the execute/memory register |
| wb_rd_i | input | REG_W | Destination held in the memory/write-back register |
| wb_regwr_i | input | 1 | Register-write flag in the memory/write-back register |
| byp_sel_o | output | NUM_SRC*2 | Bypass select per operand: 00 register file, 10 execute/memory, 01 memory/write-back |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Zero the control fields entering execute |

## Verification
The bypass selects are driven in several patterns, each built to tell one case apart from the others:
- a match in only the execute/memory stage, and a match in only the memory/write-back stage, to show which source is picked;
- a match in both stages, to expose the priority order;
- non-matching numbers, to confirm the register-file default;
- matches on register zero or with write disabled, to show that these qualifiers actually block the bypass.

The stall logic is tried three ways:
- a load with a matching decode source;
- a load into register zero, and a matching non-load producer, to separate true load-use from ordinary dependencies;
- a three-cycle sequence, to show that the stall lasts one cycle and that the released consumer then picks the write-back value.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_MEM = 2'b10
    } byp_sel_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } stall_ctl_t;
endpackage

// File: rtl/byp_select.sv
module byp_select
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_regwr_i,
    input  logic [REG_W-1:0] wb_rd_i,
    input  logic             wb_regwr_i,
    output byp_sel_e         sel_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_regwr_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == src_i);
        wb_hit  = wb_regwr_i  && (wb_rd_i  != ZERO_REG) && (wb_rd_i  == src_i);
        if (mem_hit) begin
            sel_o = BYP_MEM;
        end else if (wb_hit) begin
            sel_o = BYP_WB;
        end else begin
            sel_o = BYP_RF;
        end
    end
endmodule

// File: rtl/lduse_detect.sv
module lduse_detect #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] dec_src_i,
    input  logic [REG_W-1:0]         exe_rd_i,
    input  logic                     exe_load_i,
    input  logic                     exe_regwr_i,
    output logic                     hazard_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_hit;
    logic               producer_ok;

    assign producer_ok = exe_load_i && exe_regwr_i && (exe_rd_i != ZERO_REG);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign src_hit[s] = producer_ok && (dec_src_i[s*REG_W +: REG_W] == exe_rd_i);
    end

    assign hazard_o = |src_hit;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] dec_src_i,
    input  logic [NUM_SRC*REG_W-1:0] exe_src_i,
    input  logic [REG_W-1:0]         exe_rd_i,
    input  logic                     exe_load_i,
    input  logic                     exe_regwr_i,
    input  logic [REG_W-1:0]         mem_rd_i,
    input  logic                     mem_regwr_i,
    input  logic [REG_W-1:0]         wb_rd_i,
    input  logic                     wb_regwr_i,
    output logic [NUM_SRC*2-1:0]     byp_sel_o,
    output logic                     pc_we_o,
    output logic                     ifid_we_o,
    output logic                     bubble_o
);
    localparam int SEL_W = 2;

    logic       load_hazard;
    stall_ctl_t ctl_d;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
        byp_sel_e sel;
        byp_select #(.REG_W(REG_W)) u_sel (
            .src_i       (exe_src_i[s*REG_W +: REG_W]),
            .mem_rd_i    (mem_rd_i),
            .mem_regwr_i (mem_regwr_i),
            .wb_rd_i     (wb_rd_i),
            .wb_regwr_i  (wb_regwr_i),
            .sel_o       (sel)
        );
        assign byp_sel_o[s*SEL_W +: SEL_W] = sel;
    end

    lduse_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lduse (
        .dec_src_i   (dec_src_i),
        .exe_rd_i    (exe_rd_i),
        .exe_load_i  (exe_load_i),
        .exe_regwr_i (exe_regwr_i),
        .hazard_o    (load_hazard)
    );

    always_comb begin
        ctl_d.pc_we   = !load_hazard;
        ctl_d.ifid_we = !load_hazard;
        ctl_d.bubble  = load_hazard;
    end

    assign pc_we_o   = ctl_d.pc_we;
    assign ifid_we_o = ctl_d.ifid_we;
    assign bubble_o  = ctl_d.bubble;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic [NUM_SRC*REG_W-1:0] dec_src_i,
    input logic [NUM_SRC*REG_W-1:0] exe_src_i,
    input logic [REG_W-1:0]         exe_rd_i,
    input logic                     exe_load_i,
    input logic                     exe_regwr_i,
    input logic [REG_W-1:0]         mem_rd_i,
    input logic                     mem_regwr_i,
    input logic [REG_W-1:0]         wb_rd_i,
    input logic                     wb_regwr_i,
    input logic [NUM_SRC*2-1:0]     byp_sel_o,
    input logic                     pc_we_o,
    input logic                     ifid_we_o,
    input logic                     bubble_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] dec_match;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        logic [REG_W-1:0] src;
        logic [1:0]       sel;
        assign src = exe_src_i[s*REG_W +: REG_W];
        assign sel = byp_sel_o[s*2 +: 2];
        assign dec_match[s] = (dec_src_i[s*REG_W +: REG_W] == exe_rd_i);

        always_comb begin
            // R1
            mem_sel_valid_chk: assert (sel != 2'b10 ||
                (mem_regwr_i && mem_rd_i != ZERO_REG && mem_rd_i == src))
                else $error("select 10 without a valid execute/memory match");
            // R3
            wb_sel_valid_chk: assert (sel != 2'b01 ||
                (wb_regwr_i && wb_rd_i != ZERO_REG && wb_rd_i == src &&
                 !(mem_regwr_i && mem_rd_i == src)))
                else $error("select 01 without a valid write-back match or under priority");
            // R4
            sel_code_chk: assert (sel != 2'b11)
                else $error("unused select code");
        end
    end

    always_comb begin
        // R7
        stall_cause_chk: assert (!bubble_o ||
            (exe_load_i && exe_regwr_i && exe_rd_i != ZERO_REG && (|dec_match)))
            else $error("bubble without a load-use match");
        // R8
        no_load_no_stall_chk: assert (exe_load_i || (pc_we_o && !bubble_o))
            else $error("stall raised by a non-load");
        // R7
        freeze_pair_chk: assert ((pc_we_o == ifid_we_o) && (bubble_o == !pc_we_o))
            else $error("stall outputs disagree");
    end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .dec_src_i   (dec_src_i),
    .exe_src_i   (exe_src_i),
    .exe_rd_i    (exe_rd_i),
    .exe_load_i  (exe_load_i),
    .exe_regwr_i (exe_regwr_i),
    .mem_rd_i    (mem_rd_i),
    .mem_regwr_i (mem_regwr_i),
    .wb_rd_i     (wb_rd_i),
    .wb_regwr_i  (wb_regwr_i),
    .byp_sel_o   (byp_sel_o),
    .pc_we_o     (pc_we_o),
    .ifid_we_o   (ifid_we_o),
    .bubble_o    (bubble_o)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;
    localparam int RW = 5;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS*RW-1:0] dec_src = '0;
    logic [NS*RW-1:0] exe_src = '0;
    logic [RW-1:0] exe_rd = '0;
    logic          exe_load = 1'b0;
    logic          exe_regwr = 1'b0;
    logic [RW-1:0] mem_rd = '0;
    logic          mem_regwr = 1'b0;
    logic [RW-1:0] wb_rd = '0;
    logic          wb_regwr = 1'b0;
    logic [NS*2-1:0] byp_sel;
    logic          pc_we;
    logic          ifid_we;
    logic          bubble;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hazard_unit #(.REG_W(RW), .NUM_SRC(NS)) uut (
        .dec_src_i   (dec_src),
        .exe_src_i   (exe_src),
        .exe_rd_i    (exe_rd),
        .exe_load_i  (exe_load),
        .exe_regwr_i (exe_regwr),
        .mem_rd_i    (mem_rd),
        .mem_regwr_i (mem_regwr),
        .wb_rd_i     (wb_rd),
        .wb_regwr_i  (wb_regwr),
        .byp_sel_o   (byp_sel),
        .pc_we_o     (pc_we),
        .ifid_we_o   (ifid_we),
        .bubble_o    (bubble)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // stall view packed as {pc_we, ifid_we, bubble}
    function automatic logic [3:0] stall_v();
        return {1'b0, pc_we, ifid_we, bubble};
    endfunction

    task automatic clear();
        dec_src = '0; exe_src = '0; exe_rd = '0; exe_load = 1'b0; exe_regwr = 1'b0;
        mem_rd = '0; mem_regwr = 1'b0; wb_rd = '0; wb_regwr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        clear();
        settle();
        check("R4 reset selects", byp_sel, 4'b0000);
        check("R8 reset no stall", stall_v(), 4'b0110);
    endtask

    task automatic t_mem_bypass();
        clear();
        exe_src = {5'd4, 5'd3};
        mem_rd = 5'd3; mem_regwr = 1'b1;
        settle();
        check("R1 R10 operand0 from exe/mem", byp_sel, 4'b0010);
        exe_src = {5'd3, 5'd4};
        settle();
        check("R1 R10 operand1 from exe/mem", byp_sel, 4'b1000);
    endtask

    task automatic t_wb_bypass();
        clear();
        exe_src = {5'd4, 5'd3};
        wb_rd = 5'd4; wb_regwr = 1'b1;
        settle();
        check("R2 operand1 from mem/wb", byp_sel, 4'b0100);
        mem_rd = 5'd3; mem_regwr = 1'b1;
        settle();
        check("R10 mixed sources", byp_sel, 4'b0110);
    endtask

    task automatic t_priority();
        clear();
        exe_src = {5'd5, 5'd5};
        mem_rd = 5'd5; mem_regwr = 1'b1;
        wb_rd = 5'd5; wb_regwr = 1'b1;
        settle();
        check("R3 exe/mem wins", byp_sel, 4'b1010);
    endtask

    task automatic t_nomatch();
        clear();
        exe_src = {5'd12, 5'd3};
        mem_rd = 5'd9; mem_regwr = 1'b1;
        wb_rd = 5'd10; wb_regwr = 1'b1;
        settle();
        check("R4 no match", byp_sel, 4'b0000);
    endtask

    task automatic t_zero_reg();
        clear();
        exe_src = '0;
        mem_rd = 5'd0; mem_regwr = 1'b1;
        wb_rd = 5'd0; wb_regwr = 1'b1;
        settle();
        check("R5 zero dest no bypass", byp_sel, 4'b0000);
    endtask

    task automatic t_no_write();
        clear();
        exe_src = {5'd6, 5'd6};
        mem_rd = 5'd6; mem_regwr = 1'b0;
        wb_rd = 5'd6; wb_regwr = 1'b1;
        settle();
        check("R6 exe/mem disabled falls to mem/wb", byp_sel, 4'b0101);
        wb_regwr = 1'b0;
        settle();
        check("R6 both disabled", byp_sel, 4'b0000);
    endtask

    task automatic t_load_use();
        clear();
        exe_load = 1'b1; exe_regwr = 1'b1; exe_rd = 5'd7;
        dec_src = {5'd7, 5'd2};
        settle();
        check("R7 load-use on source1", stall_v(), 4'b0001);
        dec_src = {5'd1, 5'd7};
        settle();
        check("R7 load-use on source0", stall_v(), 4'b0001);
        dec_src = {5'd1, 5'd2};
        settle();
        check("R7 load without use", stall_v(), 4'b0110);
    endtask

    task automatic t_no_stall_cases();
        clear();
        exe_load = 1'b1; exe_regwr = 1'b1; exe_rd = 5'd0;
        dec_src = '0;
        settle();
        check("R8 load to zero reg", stall_v(), 4'b0110);
        exe_load = 1'b0; exe_rd = 5'd7;
        dec_src = {5'd7, 5'd7};
        settle();
        check("R8 ALU producer no stall", stall_v(), 4'b0110);
    endtask

    task automatic t_one_bubble();
        clear();
        // cycle 1: load r8 in execute, consumer in decode
        exe_load = 1'b1; exe_regwr = 1'b1; exe_rd = 5'd8;
        dec_src = {5'd0, 5'd8};
        settle();
        check("R9 stall cycle", stall_v(), 4'b0001);
        // cycle 2: bubble in execute, load in memory
        exe_load = 1'b0; exe_regwr = 1'b0; exe_rd = 5'd0; exe_src = '0;
        mem_rd = 5'd8; mem_regwr = 1'b1;
        settle();
        check("R9 released after one cycle", stall_v(), 4'b0110);
        // cycle 3: consumer in execute, load in write-back
        exe_src = {5'd0, 5'd8}; exe_rd = 5'd9; exe_regwr = 1'b1;
        mem_rd = 5'd0; mem_regwr = 1'b0;
        wb_rd = 5'd8; wb_regwr = 1'b1;
        dec_src = {5'd9, 5'd3};
        settle();
        check("R9 consumer takes mem/wb", byp_sel, 4'b0001);
        check("R9 no further stall", stall_v(), 4'b0110);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mem_bypass();
        t_wb_bypass();
        t_priority();
        t_nomatch();
        t_zero_reg();
        t_no_write();
        t_load_use();
        t_no_stall_cases();
        t_one_bubble();
        finish_run();
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule